// File: doc/BRIEF.md
# Staggered Row-Strobe Refresh Sequencer

This block produces the active-low row strobes for one DRAM refresh cycle. It does not pull all strobes low on the same edge. It asserts them in groups on successive rising clock edges, so the supply current drawn by the refresh is spread over several cycles. A three-bit mode input sets the group size: one strobe at a time, two at a time, or all four together. Each group holds its strobe low for a programmed number of clocks, counted from that group's own assertion edge. The groups therefore also release in staggered order.

A one-cycle request starts a refresh. While the refresh runs, a busy flag is high. A one-cycle done pulse marks the end of the refresh. A request that arrives during a refresh is kept and starts the next refresh as soon as the current one ends. Staggered refresh cannot be combined with error-scrubbing refresh, because scrubbing needs every row strobe low together. If the scrub input is high and a staggered mode is selected, the block refuses the request and flags this on a reject pulse.

Top module: `ras_stagger_seq`

## Requirements
- R1: When the block is idle, a high `rfsh_req` at a rising edge raises `busy` on that edge. No strobe goes low on that edge.
- R2: Mode code 2 (single) asserts strobe i on the (i+1)-th rising edge after the edge that raised `busy`, for i = 0..3.
- R3: Mode code 1 (pairs) asserts strobes 0 and 1 on the first rising edge after `busy` rises, and strobes 2 and 3 on the second.
- R4: Mode code 0 asserts all four strobes together on the first rising edge after `busy` rises. Codes 3 to 7 behave the same as code 0.
- R5: Each group stays low for exactly L clock cycles from its own assertion edge, where L is `low_time` (1 to 15) and a `low_time` of 0 gives L = 1.
- R6: On the rising edge after the last group negates, `busy` falls and `done` is high for exactly one cycle.
- R7: The mode and the low time are captured when a refresh is accepted. Changes to them during a refresh have no effect on that refresh.
- R8: A request that arrives while `busy` is high is held. On the edge after `done` rises, a new refresh is accepted and `busy` rises again.
- R9: A request made with `scrub_en` high in mode 1 or mode 2 is refused. `reject` is high for one cycle on the edge that would have raised `busy`, and neither a strobe nor `busy` is asserted. With `scrub_en` high in mode 0 the refresh proceeds normally.
- R10: After reset all strobes are high and `busy`, `done` and `reject` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| rfsh_req | input | 1 | Refresh start request, one cycle |
| scrub_en | input | 1 | Error-scrubbing refresh requested |
| grp_mode | input | 3 | Group-size code: 0 all, 1 pairs, 2 single, others all |
| low_time | input | 4 | Strobe low time in clocks (0 treated as 1) |
| ras_n | output | 4 | Active-low row strobes |
| busy | output | 1 | Refresh in progress |
| done | output | 1 | One-cycle pulse at the end of a refresh |
| reject | output | 1 | One-cycle pulse when a request is refused |

## Verification
The bench compares every strobe, `busy` and `done` cycle by cycle against a pattern it computes from group size and low time. It runs single mode with a mid-range low time, pairs with a short low time, all-together with a zero low time, an undefined mode code, and single mode at the maximum low time. Only single mode separates every strobe's assertion and release edges. Pairs shows whether strobes are grouped. The zero and maximum low times expose off-by-one errors and missing clamping in the per-group timers. Further runs change the mode inputs mid-refresh, issue a request during busy, and request scrubbing with each mode. These tell a latched configuration from a live one, show that a held request is kept and starts a back-to-back refresh, and show that a refusal produces no strobe activity.

// File: rtl/ras_stagger_pkg.sv
package ras_stagger_pkg;

    // Decoded group arrangement for one refresh
    typedef enum logic [1:0] {
        GK_ALL    = 2'd0,
        GK_PAIR   = 2'd1,
        GK_SINGLE = 2'd2
    } grp_kind_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } seq_state_e;

    // Raw mode codes seen on the input pin
    localparam logic [2:0] CODE_ALL    = 3'd0;
    localparam logic [2:0] CODE_PAIR   = 3'd1;
    localparam logic [2:0] CODE_SINGLE = 3'd2;

    function automatic grp_kind_e decode_mode(input logic [2:0] code);
        case (code)
            CODE_PAIR:   return GK_PAIR;
            CODE_SINGLE: return GK_SINGLE;
            default:     return GK_ALL;
        endcase
    endfunction

    function automatic logic is_staggered(input grp_kind_e k);
        return k != GK_ALL;
    endfunction

    // Which edge (0 = first after busy) a given strobe lane asserts on
    function automatic int lane_group(input int idx, input grp_kind_e k);
        case (k)
            GK_SINGLE: return idx;
            GK_PAIR:   return idx / 2;
            default:   return 0;
        endcase
    endfunction

endpackage

// File: rtl/ras_stagger_ctrl.sv
module ras_stagger_ctrl
    import ras_stagger_pkg::*;
#(
    parameter int LOW_W  = 4,
    parameter int STEP_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rfsh_req,
    input  logic              scrub_en,
    input  logic [2:0]        grp_mode,
    input  logic [LOW_W-1:0]  low_time,
    input  logic              all_finished,
    output logic              run,
    output logic              lane_clr,
    output logic [STEP_W-1:0] step,
    output grp_kind_e         kind,
    output logic [LOW_W-1:0]  low_cyc,
    output logic              busy,
    output logic              done,
    output logic              reject
);

    localparam logic [STEP_W-1:0] STEP_MAX = '1;

    seq_state_e state;
    logic       pend;
    logic       start_try;
    logic       refuse;
    logic       accept;
    grp_kind_e  req_kind;

    assign req_kind  = decode_mode(grp_mode);
    assign start_try = (state == ST_IDLE) && (rfsh_req || pend);
    assign refuse    = start_try && scrub_en && is_staggered(req_kind);
    assign accept    = start_try && !refuse;

    assign run      = (state == ST_RUN);
    assign lane_clr = accept;
    assign busy     = run;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            pend    <= 1'b0;
            step    <= '0;
            kind    <= GK_ALL;
            low_cyc <= LOW_W'(1);
            done    <= 1'b0;
            reject  <= 1'b0;
        end else begin
            done   <= 1'b0;
            reject <= refuse;

            if (start_try)
                pend <= 1'b0;
            else if (run && rfsh_req)
                pend <= 1'b1;

            if (accept) begin
                state   <= ST_RUN;
                step    <= '0;
                kind    <= req_kind;
                low_cyc <= (low_time == '0) ? LOW_W'(1) : low_time;
            end else if (run) begin
                if (step != STEP_MAX)
                    step <= step + 1'b1;
                if (all_finished) begin
                    state <= ST_IDLE;
                    done  <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/ras_stagger_lane.sv
module ras_stagger_lane #(
    parameter int LOW_W  = 4,
    parameter int STEP_W = 3,
    parameter int OFF_W  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              run,
    input  logic [STEP_W-1:0] step,
    input  logic [OFF_W-1:0]  offset,
    input  logic [LOW_W-1:0]  low_cyc,
    output logic              ras_n,
    output logic              finished
);

    logic             fired;
    logic [LOW_W-1:0] cnt;
    logic             fire;

    assign fire     = run && !fired && (step == STEP_W'(offset));
    assign finished = fired && ras_n;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            ras_n <= 1'b1;
            fired <= 1'b0;
            cnt   <= '0;
        end else if (fire) begin
            ras_n <= 1'b0;
            fired <= 1'b1;
            cnt   <= low_cyc - 1'b1;
        end else if (!ras_n) begin
            if (cnt == '0)
                ras_n <= 1'b1;
            else
                cnt <= cnt - 1'b1;
        end
    end

endmodule

// File: rtl/ras_stagger_seq.sv
module ras_stagger_seq
    import ras_stagger_pkg::*;
#(
    parameter int N_RAS = 4,
    parameter int LOW_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rfsh_req,
    input  logic             scrub_en,
    input  logic [2:0]       grp_mode,
    input  logic [LOW_W-1:0] low_time,
    output logic [N_RAS-1:0] ras_n,
    output logic             busy,
    output logic             done,
    output logic             reject
);

    localparam int OFF_W  = (N_RAS > 1) ? $clog2(N_RAS) : 1;
    localparam int STEP_W = OFF_W + 1;

    logic              run;
    logic              lane_clr;
    logic [STEP_W-1:0] step;
    grp_kind_e         kind;
    logic [LOW_W-1:0]  low_cyc;
    logic [N_RAS-1:0]  lane_fin;

    ras_stagger_ctrl #(.LOW_W(LOW_W), .STEP_W(STEP_W)) i_ctrl (
        .clk          (clk),
        .rst          (rst),
        .rfsh_req     (rfsh_req),
        .scrub_en     (scrub_en),
        .grp_mode     (grp_mode),
        .low_time     (low_time),
        .all_finished (&lane_fin),
        .run          (run),
        .lane_clr     (lane_clr),
        .step         (step),
        .kind         (kind),
        .low_cyc      (low_cyc),
        .busy         (busy),
        .done         (done),
        .reject       (reject)
    );

    for (genvar gi = 0; gi < N_RAS; gi++) begin : g_lane
        logic [OFF_W-1:0] off;
        assign off = OFF_W'(lane_group(gi, kind));

        ras_stagger_lane #(.LOW_W(LOW_W), .STEP_W(STEP_W), .OFF_W(OFF_W)) i_lane (
            .clk      (clk),
            .rst      (rst),
            .clr      (lane_clr),
            .run      (run),
            .step     (step),
            .offset   (off),
            .low_cyc  (low_cyc),
            .ras_n    (ras_n[gi]),
            .finished (lane_fin[gi])
        );
    end

endmodule

// File: rtl/ras_stagger_chk.sv
module ras_stagger_chk #(
    parameter int N_RAS = 4
) (
    input logic             clk,
    input logic             rst,
    input logic [N_RAS-1:0] ras_n,
    input logic             busy,
    input logic             done,
    input logic             reject
);

    // R10: reset leaves all outputs idle
    a_r10_reset_idle: assert property (@(posedge clk)
        rst |=> ((&ras_n) && !busy && !done && !reject));

    // R1: no strobe on the acceptance edge
    a_r1_no_strobe_on_accept: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> (&ras_n));

    // R5: a strobe is only low during a refresh
    a_r5_low_needs_busy: assert property (@(posedge clk) disable iff (rst)
        !(&ras_n) |-> busy);

    // R6: done lasts one cycle
    a_r6_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R6: done ends a refresh with all strobes released
    a_r6_done_ends_busy: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy) && (&ras_n)));

    // R9: a refused request leaves the strobes and busy quiet
    a_r9_refuse_quiet: assert property (@(posedge clk) disable iff (rst)
        reject |-> ((&ras_n) && !busy));

endmodule

bind ras_stagger_seq ras_stagger_chk #(.N_RAS(N_RAS)) i_chk (
    .clk    (clk),
    .rst    (rst),
    .ras_n  (ras_n),
    .busy   (busy),
    .done   (done),
    .reject (reject)
);

// File: tb/test_ras_stagger_seq.sv
module test_ras_stagger_seq;

    localparam int CLK_PERIOD = 10;
    localparam int NR = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rfsh_req = 1'b0;
    logic       scrub_en = 1'b0;
    logic [2:0] grp_mode = 3'd0;
    logic [3:0] low_time = 4'd1;
    logic [3:0] ras_n;
    logic       busy, done, reject;

    int n_cmp = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ras_stagger_seq i_ras_stagger_seq (
        .clk(clk), .rst(rst), .rfsh_req(rfsh_req), .scrub_en(scrub_en),
        .grp_mode(grp_mode), .low_time(low_time),
        .ras_n(ras_n), .busy(busy), .done(done), .reject(reject)
    );

    task automatic cmp(input string tag, input logic [6:0] exp);
        logic [6:0] got;
        got = {ras_n, busy, done, reject};
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s t=%0t {ras_n,busy,done,reject} got=%b exp=%b", tag, $time, got, exp);
        end
    endtask

    // Pulse a request; returns at the sample after the accepting edge (j=1)
    task automatic start_req();
        @(negedge clk);
        rfsh_req = 1'b1;
        @(negedge clk);
        rfsh_req = 1'b0;
    endtask

    // Compare a whole refresh, from sample j=1 (busy just risen) to the done sample.
    // gs = strobes per group, lt = programmed low time.
    task automatic check_run(input string tag, input int gs, input int lt,
                             input int pend_at, input int chg_at);
        int L, G, last;
        logic [3:0] er;
        L = (lt == 0) ? 1 : lt;
        G = NR / gs;
        last = G + L + 2;
        for (int j = 1; j <= last; j++) begin
            for (int i = 0; i < NR; i++) begin
                int g;
                g = i / gs;
                er[i] = !((j >= g + 2) && (j <= g + L + 1));
            end
            cmp(tag, {er, (j <= G + L + 1), (j == last), 1'b0});
            if (pend_at != 0 && j == pend_at) rfsh_req = 1'b1;
            if (pend_at != 0 && j == pend_at + 1) rfsh_req = 1'b0;
            if (chg_at != 0 && j == chg_at) begin
                grp_mode = 3'd2;
                low_time = 4'd15;
            end
            @(negedge clk);
        end
    endtask

    task automatic check_idle(input string tag);
        cmp(tag, {4'hF, 1'b0, 1'b0, 1'b0});
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check_idle("R10 during reset");
        rst = 1'b0;
        @(negedge clk);
        check_idle("R10 after reset");
    endtask

    task automatic t_single();
        grp_mode = 3'd2; low_time = 4'd3;
        start_req();
        check_run("R1 R2 R5 R6 single L3", 1, 3, 0, 0);
        check_idle("R6 idle after single");
    endtask

    task automatic t_pairs();
        grp_mode = 3'd1; low_time = 4'd2;
        start_req();
        check_run("R3 R5 R6 pairs L2", 2, 2, 0, 0);
        check_idle("R6 idle after pairs");
    endtask

    task automatic t_all_zero();
        grp_mode = 3'd0; low_time = 4'd0;
        start_req();
        check_run("R4 R5 all L0->1", 4, 0, 0, 0);
        check_idle("R6 idle after all");
    endtask

    task automatic t_odd_code();
        grp_mode = 3'd5; low_time = 4'd1;
        start_req();
        check_run("R4 code5 as all", 4, 1, 0, 0);
        check_idle("R4 idle after code5");
    endtask

    task automatic t_max_low();
        grp_mode = 3'd2; low_time = 4'd15;
        start_req();
        check_run("R5 single L15", 1, 15, 0, 0);
        check_idle("R5 idle after L15");
    endtask

    task automatic t_latch();
        grp_mode = 3'd1; low_time = 4'd4;
        start_req();
        check_run("R7 config latched", 2, 4, 0, 2);
        check_idle("R7 idle after latch");
    endtask

    task automatic t_pending();
        grp_mode = 3'd2; low_time = 4'd2;
        start_req();
        check_run("R8 first run", 1, 2, 3, 0);
        check_run("R8 pending run", 1, 2, 0, 0);
        check_idle("R8 no third run");
    endtask

    task automatic t_refuse();
        scrub_en = 1'b1;
        grp_mode = 3'd2; low_time = 4'd2;
        start_req();
        cmp("R9 refuse single", {4'hF, 1'b0, 1'b0, 1'b1});
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check_idle("R9 quiet after refuse single");
        end
        grp_mode = 3'd1;
        start_req();
        cmp("R9 refuse pairs", {4'hF, 1'b0, 1'b0, 1'b1});
        @(negedge clk);
        check_idle("R9 quiet after refuse pairs");
        grp_mode = 3'd0; low_time = 4'd3;
        start_req();
        check_run("R9 scrub with all proceeds", 4, 3, 0, 0);
        check_idle("R9 idle after scrub all");
        scrub_en = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_single();
        t_pairs();
        t_all_zero();
        t_odd_code();
        t_max_low();
        t_latch();
        t_pending();
        t_refuse();
        repeat (2) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule